// File: doc/BRIEF.md
# Link Stress Pattern Generator

This block drives a 21-bit parallel pixel word, one word per pixel clock, into the input of a serial video link transmitter so that the link can be exercised under controlled switching. It has two patterns. The toggle pattern gives the low four bits of every colour channel square waves at binary fractions of the pixel rate, so the serializer sees as many transitions as it can. The gray pattern steps one shared 4-bit level through the upper colour bits, so that a panel shows repeating groups of 16 vertical stripes.

The word holds three 6-bit colour channels and three control lines. Red occupies indices 0 to 5, green 6 to 11, blue 12 to 17, and line sync, frame sync and data enable sit on 18, 19 and 20. Both patterns hold the three control lines high and the unused colour bits low. A free-running phase counter and a stripe level counter advance only on enabled pixel clocks. They keep running across a change of pattern, so a switch shows at the next edge with no loss of phase. A synchronous reset puts both counters and the output word back to a known starting point.

Top module: `stress_pattern_gen`

## Requirements
- R1: A clock edge with `rst` high sets `pix_o` to all zeros and returns both counters to zero. The first enabled edge after that emits the pattern for phase 0 and level 0.
- R2: The bit indices are fixed: red bit n is `pix_o[n]`, green bit n is `pix_o[6+n]` and blue bit n is `pix_o[12+n]`, for n from 0 to 5. Line sync is `pix_o[18]`, frame sync `pix_o[19]` and data enable `pix_o[20]`. The second enabled word after reset in toggle mode is 0x1C8208.
- R3: In toggle mode, colour bit k (k = 0..3) of each channel is a square wave with a period of 16, 8, 4 and 2 enabled pixels for k = 0, 1, 2, 3. Every one of these waves starts low on the first word after reset.
- R4: In toggle mode, colour bits 4 and 5 of every channel are low.
- R5: In both modes, every word emitted after reset has the three control bits 18, 19 and 20 high.
- R6: In gray mode, bits 2 to 5 of every channel carry the same 4-bit level, and bits 0 and 1 are low. All three channels are equal.
- R7: The level advances by one after every STEP_PIX enabled pixels, with a default of 4, and wraps from 15 to 0, so that the sequence repeats after 16 steps.
- R8: While `en` is low, `pix_o` and both counters hold their values.
- R9: `mode_i` selects the pattern: 0 is toggle and 1 is gray. A change of `mode_i` shows in the word emitted at the next enabled edge, and neither counter restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Pixel advance enable; when low all state holds |
| mode_i | input | 1 | Pattern select: 0 toggle, 1 gray |
| pix_o | output | 21 | Registered pixel word toward the serializer |

## Verification
On every cycle the embedded assertions check the following: the phase counter steps by one per enabled pixel, the level steps only at the end of each STEP_PIX run, the output word holds while the block is disabled, and each mode keeps its fixed bits. In gray mode that means equal channels with bits 0 and 1 low; in both modes it means high control lines. The exact phase of each square wave, the wrap of the level after 16 steps, and the continuity of phase across a mode change or a gap in the enable can only be seen by comparing full words against the bench's reference model. That comparison covers a run of reset, toggle, gray and mixed stimulus.

// File: rtl/stress_pkg.sv
package stress_pkg;

    localparam int PHASE_W = 4;
    localparam int LEVEL_W = 4;
    localparam int CHAN_W  = 6;
    localparam int NUM_CH  = 3;
    localparam int CTL_W   = 3;
    localparam int PIX_W   = NUM_CH * CHAN_W + CTL_W;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_GRAY   = 1'b1
    } mode_e;

    // Packed so that red lands on the lowest indices and data enable on the top.
    typedef struct packed {
        logic              de;
        logic              vs;
        logic              hs;
        logic [CHAN_W-1:0] blu;
        logic [CHAN_W-1:0] grn;
        logic [CHAN_W-1:0] red;
    } pix_t;

    // The fastest wave sits on the highest toggling bit: colour bit i follows phase bit PHASE_W-1-i.
    function automatic logic [CHAN_W-1:0] toggle_chan(input logic [PHASE_W-1:0] ph);
        logic [CHAN_W-1:0] r;
        r = '0;
        for (int i = 0; i < PHASE_W; i++) begin
            r[i] = ph[PHASE_W-1-i];
        end
        return r;
    endfunction

    // The level occupies the top bits of the channel; the lower bits stay low.
    function automatic logic [CHAN_W-1:0] gray_chan(input logic [LEVEL_W-1:0] lv);
        logic [CHAN_W-1:0] r;
        r = '0;
        r[CHAN_W-1 -: LEVEL_W] = lv;
        return r;
    endfunction

endpackage

// File: rtl/stress_phase_ctr.sv
module stress_phase_ctr
    import stress_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] ph_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_o <= '0;
        end else if (en) begin
            ph_o <= ph_o + 1'b1;
        end
    end

    // R3: one phase step per enabled pixel, wrapping modulo 2**W
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && en) |=> (ph_o == W'($past(ph_o) + 1'b1)));

    // R8: phase frozen while disabled
    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !en) |=> $stable(ph_o));

endmodule

// File: rtl/stress_level_ctr.sv
module stress_level_ctr
    import stress_pkg::*;
#(
    parameter int STEP_PIX = 4,
    parameter int LW       = LEVEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [LW-1:0] lvl_o
);

    logic step;

    generate
        if (STEP_PIX <= 1) begin : g_every
            assign step = en;
        end else begin : g_run
            localparam int SC_W = $clog2(STEP_PIX);
            localparam logic [SC_W-1:0] SC_LAST = SC_W'(STEP_PIX - 1);
            logic [SC_W-1:0] sc;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sc <= '0;
                end else if (en) begin
                    sc <= (sc == SC_LAST) ? '0 : sc + 1'b1;
                end
            end

            assign step = en && (sc == SC_LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_o <= '0;
        end else if (step) begin
            lvl_o <= lvl_o + 1'b1;
        end
    end

    // R7: level moves up by one, wrapping, at the end of each run
    assert_level_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && step) |=> (lvl_o == LW'($past(lvl_o) + 1'b1)));

    // R7: level steady inside a run and while disabled
    assert_level_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && !step) |=> $stable(lvl_o));

endmodule

// File: rtl/stress_pattern_mux.sv
module stress_pattern_mux
    import stress_pkg::*;
(
    input  mode_e              mode,
    input  logic [PHASE_W-1:0] ph,
    input  logic [LEVEL_W-1:0] lvl,
    output pix_t               pix
);

    logic [CHAN_W-1:0] chan [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            always_comb begin
                if (mode == MODE_GRAY) begin
                    chan[c] = gray_chan(lvl);
                end else begin
                    chan[c] = toggle_chan(ph);
                end
            end
        end
    endgenerate

    always_comb begin
        pix.red = chan[0];
        pix.grn = chan[1];
        pix.blu = chan[2];
        pix.hs  = 1'b1;
        pix.vs  = 1'b1;
        pix.de  = 1'b1;
    end

endmodule

// File: rtl/stress_pattern_gen.sv
module stress_pattern_gen
    import stress_pkg::*;
#(
    parameter int STEP_PIX = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode_i,
    output logic [PIX_W-1:0] pix_o
);

    mode_e              mode;
    logic [PHASE_W-1:0] ph;
    logic [LEVEL_W-1:0] lvl;
    pix_t               nxt;
    pix_t               q;

    assign mode = mode_e'(mode_i);

    stress_phase_ctr #(.W(PHASE_W)) i_phase (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .ph_o (ph)
    );

    stress_level_ctr #(.STEP_PIX(STEP_PIX), .LW(LEVEL_W)) i_level (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .lvl_o (lvl)
    );

    stress_pattern_mux i_mux (
        .mode (mode),
        .ph   (ph),
        .lvl  (lvl),
        .pix  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= nxt;
        end
    end

    assign pix_o = q;

    // R8: output word frozen while disabled
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !en) |=> $stable(pix_o));

    // R4 and R5: toggle words keep upper colour bits low and controls high
    assert_toggle_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && mode == MODE_TOGGLE) |=>
        (q.red[5:4] == 2'b00 && q.grn[5:4] == 2'b00 && q.blu[5:4] == 2'b00 &&
         {q.de, q.vs, q.hs} == 3'b111));

    // R6 and R5: gray words have equal channels, low bottom bits, high controls
    assert_gray_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && en && mode == MODE_GRAY) |=>
        (q.red == q.grn && q.grn == q.blu && q.red[1:0] == 2'b00 &&
         {q.de, q.vs, q.hs} == 3'b111));

endmodule

// File: tb/test_stress_pattern_gen.sv
module test_stress_pattern_gen;

    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 4;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mode_i = 1'b0;
    logic [20:0] pix_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit checking = 1'b0;
    string cur_tag = "R1";

    int          m_ph = 0;
    int          m_sc = 0;
    int          m_lvl = 0;
    logic [20:0] m_exp = '0;

    stress_pattern_gen #(.STEP_PIX(STEP)) i_stress_pattern_gen (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .mode_i (mode_i),
        .pix_o  (pix_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Word expected from the requirements for a given mode, phase and level
    function automatic logic [20:0] expect_word(input logic gray, input int ph, input int lvl);
        logic [20:0] w;
        logic [5:0]  c;
        c = '0;
        if (gray) begin
            c = 6'(lvl * 4);
        end else begin
            for (int k = 0; k < 4; k++) begin
                // bit k has a period of 16>>k pixels, low for the first half
                c[k] = ((ph / (8 >> k)) % 2) == 1;
            end
        end
        w = '0;
        for (int n = 0; n < 6; n++) begin
            w[n]      = c[n];
            w[6 + n]  = c[n];
            w[12 + n] = c[n];
        end
        w[18] = 1'b1;
        w[19] = 1'b1;
        w[20] = 1'b1;
        return w;
    endfunction

    // Reference model: behavioural update on each rising edge
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (rst) begin
            m_ph = 0;
            m_sc = 0;
            m_lvl = 0;
            m_exp = '0;
            checking = 1'b1;
        end else if (en) begin
            m_exp = expect_word(mode_i, m_ph, m_lvl);
            m_ph = (m_ph + 1) % 16;
            m_sc = m_sc + 1;
            if (m_sc == STEP) begin
                m_sc = 0;
                m_lvl = (m_lvl + 1) % 16;
            end
        end
    end

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: pix_o=%06h expected=%06h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            check(cur_tag, pix_o, m_exp);
        end
    end

    task automatic run(input int n, input logic e, input logic m, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_tag = tag;
            en = e;
            mode_i = m;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset word
        check("R1", pix_o, 21'h000000);
        run(1, 1'b1, 1'b0, "R1");
        rst = 1'b0;
        @(negedge clk);
        // R1 and R3: first word is phase 0, all toggling bits low
        check("R1", pix_o, 21'h1C0000);
        @(negedge clk);
        // R2: bit 3 of each colour plus controls
        check("R2", pix_o, 21'h1C8208);
        run(40, 1'b1, 1'b0, "R3");
        run(20, 1'b1, 1'b0, "R4");
        // R8: gaps in enable
        for (int i = 0; i < 12; i++) begin
            run(1, (i % 3) != 0, 1'b0, "R8");
        end
        run(5, 1'b0, 1'b0, "R8");
        // R6, R7: full gray sweep past the wrap
        run(80, 1'b1, 1'b1, "R6");
        run(70, 1'b1, 1'b1, "R7");
        run(5, 1'b0, 1'b1, "R8");
        // R9: switches mid-stream without counter restart
        for (int i = 0; i < 30; i++) begin
            run(1, 1'b1, (i % 5) < 2, "R9");
        end
        run(7, 1'b1, 1'b0, "R5");
        // R1: reset mid-run, then restart
        @(negedge clk);
        rst = 1'b1;
        cur_tag = "R1";
        @(negedge clk);
        rst = 1'b0;
        check("R1", pix_o, 21'h000000);
        run(20, 1'b1, 1'b1, "R7");
        run(20, 1'b1, 1'b0, "R3");
        @(negedge clk);
        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule